// File: doc/BRIEF.md
# Dual-Source Baud Tick Generator

This block produces the bit-rate timing strobe for a serial transmitter and receiver. It holds a configuration word with three fields: a divisor, a flag that enables the divisor, and a select for the clock path. The select chooses one of two fixed prescalers, divide by 3 or divide by 4. The prescaler output steps a reload divider that counts from 0 to the programmed divisor and then wraps. Each wrap emits one tick, a pulse one system clock wide.

Software writes the whole word in one cycle. Every write restarts the prescaler and the divider, so the timing of a new rate starts cleanly from the write. The serial engines and the choice of clock lie outside this block. With a 4 to 24 MHz system clock, the divisor range covers rates from 50 baud up to several megabaud.

Top module: `baud_gen`

## Requirements
- R1: After reset, `tick_o` and `enabled_o` are low, and they stay low until a configuration word with the enable bit set is written.
- R2: `cfg_wdata_i` is captured on a rising edge where `cfg_we_i` is high. Bits 22:0 hold the divisor N, bit 23 is the enable flag, and bit 24 is the path select. `enabled_o` equals bit 23 of the last write from the next cycle on.
- R3: With bit 24 = 1 and bit 23 = 1, ticks repeat every 3·(N+1) clock cycles.
- R4: With bit 24 = 0 and bit 23 = 1, ticks repeat every 4·(N+1) clock cycles.
- R5: A write restarts the timing, even when it rewrites the same value. The first tick is high in the cycle that begins exactly one full period, P·(N+1) edges, after the write edge.
- R6: While bit 23 is clear, no tick is produced.
- R7: A tick lasts exactly one cycle, and two ticks are never closer than 3 cycles apart.
- R8: A write that lands on the edge where a tick would have been raised cancels that tick. The next tick then follows one full period of the new setting.
- R9: The divisor boundaries work. N = 0 with the divide-by-3 path gives a tick every 3 cycles. N = 2^23−1 is accepted and gives no tick within the first thousand cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Write strobe for the configuration word |
| cfg_wdata_i | input | 25 | Configuration word: divisor [22:0], enable [23], path select [24] |
| tick_o | output | 1 | Single-cycle bit-rate tick |
| enabled_o | output | 1 | Divisor-enable flag currently in force |

## Verification
A configuration write and a tick can fall on the same clock edge. To provoke this, the bench programs a rate and waits until the cycle just before the predicted tick. It then issues a second write, so that the write edge is the edge on which the old tick would have been raised. The check requires `tick_o` to stay low in that cycle, and the first tick afterwards to come one full period of the new setting after the write edge. Any leftover prescaler or divider state would shift that tick, so a single late or early tick is enough to fail the check.

// File: rtl/baud_gen_pkg.sv
package baud_gen_pkg;
  localparam int unsigned DIV_W_DEF  = 23;
  localparam int unsigned PRE_A_DEF  = 3;  // path select = 1
  localparam int unsigned PRE_B_DEF  = 4;  // path select = 0

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/baud_cfg_reg.sv
module baud_cfg_reg #(
  parameter int unsigned DIV_W = baud_gen_pkg::DIV_W_DEF,
  localparam int unsigned CFG_W = DIV_W + 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [CFG_W-1:0] wdata_i,
  output logic [DIV_W-1:0] divisor_o,
  output logic             use_o,
  output logic             sel_o,
  output logic             restart_o
);
  logic [CFG_W-1:0] cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cfg_q <= '0;
    else if (we_i) cfg_q <= wdata_i;
  end

  assign divisor_o = cfg_q[DIV_W-1:0];
  assign use_o     = cfg_q[DIV_W];
  assign sel_o     = cfg_q[DIV_W+1];
  assign restart_o = we_i;
endmodule

// File: rtl/baud_prescaler.sv
module baud_prescaler #(
  parameter int unsigned PRE_A = baud_gen_pkg::PRE_A_DEF,
  parameter int unsigned PRE_B = baud_gen_pkg::PRE_B_DEF,
  localparam int unsigned PMAX = baud_gen_pkg::max_u(PRE_A, PRE_B),
  localparam int unsigned CW   = (PMAX > 2) ? $clog2(PMAX) : 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  input  logic run_i,
  input  logic sel_i,
  output logic strobe_o
);
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] lim_m1;
  logic          at_lim;

  assign lim_m1 = sel_i ? CW'(PRE_A - 1) : CW'(PRE_B - 1);
  assign at_lim = (cnt_q == lim_m1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (restart_i || !run_i) cnt_q <= '0;
    else if (at_lim)             cnt_q <= '0;
    else                         cnt_q <= cnt_q + 1'b1;
  end

  assign strobe_o = run_i && !restart_i && at_lim;

  // R3 R4
  pre_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= lim_m1);
endmodule

// File: rtl/baud_divider.sv
module baud_divider #(
  parameter int unsigned DIV_W = baud_gen_pkg::DIV_W_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic             run_i,
  input  logic             step_i,
  input  logic [DIV_W-1:0] divisor_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;
  logic             wrap;
  logic             tick_q;

  assign wrap = step_i && (cnt_q == divisor_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else if (restart_i || !run_i) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      tick_q <= wrap;
      if (wrap)        cnt_q <= '0;
      else if (step_i) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign tick_o = tick_q;

  // R3 R4
  div_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> cnt_q <= divisor_i);
endmodule

// File: rtl/baud_gen.sv
module baud_gen #(
  parameter int unsigned DIV_W = baud_gen_pkg::DIV_W_DEF,
  parameter int unsigned PRE_A = baud_gen_pkg::PRE_A_DEF,
  parameter int unsigned PRE_B = baud_gen_pkg::PRE_B_DEF,
  localparam int unsigned CFG_W = DIV_W + 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [CFG_W-1:0] cfg_wdata_i,
  output logic             tick_o,
  output logic             enabled_o
);
  logic [DIV_W-1:0] divisor;
  logic             use_div, sel, restart, pre_strobe;

  baud_cfg_reg #(.DIV_W(DIV_W)) u_cfg (
    .clk_i, .rst_ni, .we_i(cfg_we_i), .wdata_i(cfg_wdata_i),
    .divisor_o(divisor), .use_o(use_div), .sel_o(sel), .restart_o(restart)
  );

  baud_prescaler #(.PRE_A(PRE_A), .PRE_B(PRE_B)) u_pre (
    .clk_i, .rst_ni, .restart_i(restart), .run_i(use_div), .sel_i(sel),
    .strobe_o(pre_strobe)
  );

  baud_divider #(.DIV_W(DIV_W)) u_div (
    .clk_i, .rst_ni, .restart_i(restart), .run_i(use_div),
    .step_i(pre_strobe), .divisor_i(divisor), .tick_o(tick_o)
  );

  assign enabled_o = use_div;

  // R6
  tick_needs_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |-> enabled_o);
  // R7
  tick_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);
  // R8
  write_cancels_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i |=> !tick_o);
  // R2
  en_follows_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i |=> enabled_o == $past(cfg_wdata_i[DIV_W]));
endmodule

// File: tb/sim_baud_gen.sv
`timescale 1ns/1ps
module sim_baud_gen;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [24:0] cfg_wdata_i = '0;
  logic        tick_o, enabled_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk_i = ~clk_i;

  baud_gen u0 (.clk_i, .rst_ni, .cfg_we_i, .cfg_wdata_i, .tick_o, .enabled_o);

  function automatic int period_of(input bit sel, input int n);
    return (sel ? 3 : 4) * (n + 1);
  endfunction

  function automatic logic [24:0] word(input bit sel, input bit en, input int n);
    return {sel, en, 23'(n)};
  endfunction

  task automatic check1(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  // called at a negedge; returns at the negedge right after the write edge
  task automatic write_cfg(input logic [24:0] v);
    cfg_we_i = 1'b1;
    cfg_wdata_i = v;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
  endtask

  // t = 0 means no tick expected
  task automatic check_run(input string req, input int t, input int ncyc);
    bit bad = 0;
    checks++;
    for (int c = 1; c <= ncyc; c++) begin
      logic exp;
      @(negedge clk_i);
      exp = (t > 0) && (c % t == 0);
      if (!bad && tick_o !== exp) begin
        bad = 1;
        errors++;
        $display("FAIL %s period=%0d cycle=%0d actual=%b expected=%b", req, t, c, tick_o, exp);
      end
    end
  endtask

  initial begin
    int unsigned seed;
    seed = $urandom(32'd4711);
    repeat (3) @(negedge clk_i);
    // R1
    check1("R1 tick", tick_o, 1'b0);
    check1("R1 enabled", enabled_o, 1'b0);
    rst_ni = 1'b1;
    check_run("R1 idle", 0, 20);

    // R3 directed, R9 fastest rate
    write_cfg(word(1, 1, 0));
    check1("R2 enabled", enabled_o, 1'b1);
    check_run("R9 n0 div3", 3, 12);
    // R4 directed
    write_cfg(word(0, 1, 2));
    check_run("R4 n2 div4", 12, 37);
    write_cfg(word(0, 1, 0));
    check_run("R4 n0 div4", 4, 17);

    // random rates, R3 and R4 and R5
    for (int i = 0; i < 30; i++) begin
      bit s;
      int n;
      s = 1'($urandom);
      n = int'($urandom % 25);
      write_cfg(word(s, 1, n));
      check_run(s ? "R3 random" : "R4 random", period_of(s, n), 2 * period_of(s, n) + 1);
    end

    // R5 rewrite of same value mid-period restarts timing
    write_cfg(word(1, 1, 3));
    repeat (5) @(negedge clk_i);
    write_cfg(word(1, 1, 3));
    check_run("R5 rewrite", 12, 25);

    // R6 enable cleared
    write_cfg(word(1, 0, 1));
    check1("R6 enabled low", enabled_o, 1'b0);
    check_run("R6 no tick", 0, 60);

    // R8 write on the tick edge
    for (int k = 0; k < 4; k++) begin
      bit s;
      int n, t, t2;
      s = 1'($urandom);
      n = int'($urandom % 6);
      t = period_of(s, n);
      write_cfg(word(s, 1, n));
      repeat (t - 1) @(negedge clk_i);
      s = 1'($urandom);
      n = int'($urandom % 6);
      t2 = period_of(s, n);
      write_cfg(word(s, 1, n));
      check1("R8 cancelled tick", tick_o, 1'b0);
      check_run("R8 new period", t2, 2 * t2 + 1);
    end

    // R9 max divisor
    write_cfg(word(0, 1, 32'h7FFFFF));
    check1("R9 enabled", enabled_o, 1'b1);
    check_run("R9 max divisor", 0, 1000);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule